// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Sensing

This block is a 32-pin general-purpose I/O port behind a simple word-addressed register interface. Each pin can be turned into an output that drives the value held in an output latch, or left as an input. Every incoming pad value passes through a two-flop synchroniser before any logic uses it.

Each pin has a 2-bit sense code that selects low level, high level, rising edge or falling edge detection. The codes for pins 0 to 15 sit in one configuration register and those for pins 16 to 31 in a second one. A separate per-pin any-edge bit overrides the code so that the pin fires on either edge. Detected events set bits in a sticky status register whatever the mask says, and software clears them by writing 1s. A registered interrupt line is raised whenever an unmasked status bit is set.

Software reaches the block through a valid strobe, a write flag, a 3-bit word address and 32-bit data. Reads return their data one cycle after the request. Every register except the pad view can be read back, so one pin can be changed by read-modify-write.

Top module: `gpio_port`

## Requirements
- R1: After reset every register (output latch, direction, mask, both sense registers, any-edge) reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: `pad_oe[n]` equals direction bit n (1 = output), and `pad_out` equals the output latch.
- R3: A read of the data register (address 0) returns the output latch bit for pins whose direction bit is 1 and the synchronised pad bit for pins whose direction bit is 0. The pad register (address 2) always returns the synchronised pad value and ignores writes.
- R4: A pad change reaches the synchronised value after exactly two rising clock edges.
- R5: Pin n's sense code is at bits [2n+1:2n] of the low sense register (address 5) for n < 16, and at bits [2(n-16)+1:2(n-16)] of the high sense register (address 6) for n >= 16. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R6: When any-edge bit n (address 7) is 1, pin n fires on every rising and every falling edge, whatever its sense code says, and does not fire on a steady level.
- R7: A qualifying event sets status bit n (address 4) even when the pin is masked. In a level mode the bit is set again on every cycle while the level holds.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear wins.
- R9: `irq` is a register holding the OR over all pins of status AND mask (address 3). It rises on the fourth rising edge after an unmasked edge reaches the pad.
- R10: Address map: 0 data, 1 direction, 2 pad, 3 mask, 4 status, 5 low sense, 6 high sense, 7 any-edge. A write changes only the addressed register. `reg_rdata` is updated one cycle after a read request and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the request |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Output latch value driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an edge event on a pin whose any-edge bit contradicts its sense code, because the mode change itself and every earlier pad level leave status bits set. For each table vector the bench first configures the pin and settles the pad at its starting level. It then clears the pin's status with a write-1, applies the second level and reads the bit back. The expected value therefore depends only on the one transition the vector names and on the level rules. The latency of `irq` is checked on exact clock edges after a single unmasked rising edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PAD    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] A_SNS_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_SNS_HI = 3'd6;
  localparam logic [ADDR_W-1:0] A_ANYEDG = 3'd7;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  // Per-pin event: any-edge overrides the 2-bit code.
  function automatic logic pin_event(input logic [1:0] code, input logic any,
                                     input logic cur, input logic prev);
    logic hit;
    if (any) hit = cur ^ prev;
    else begin
      case (sense_e'(code))
        SENSE_LOW:  hit = ~cur;
        SENSE_HIGH: hit = cur;
        SENSE_RISE: hit = cur & ~prev;
        default:    hit = ~cur & prev;
      endcase
    end
    return hit;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;
  logic [1:0]   warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      warm <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign q = s2;

  // R4: two edges from pad to synchronised value
  a_r4_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int unsigned N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   cur,
  input  logic [2*N-1:0] sense,
  input  logic [N-1:0]   any_edge,
  output logic [N-1:0]   ev
);
  import gpio_port_pkg::*;

  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign ev[i] = pin_event(sense[2*i +: 2], any_edge[i], cur[i], prev[i]);

    // R6: edge-type pins fire only when the synchronised value moved
    a_r6_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      ((any_edge[i] || sense[2*i+1]) && ev[i]) |-> (cur[i] != prev[i]));
  end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
      live   <= 1'b0;
    end else begin
      status <= (status & ~clr) | ev;
      irq    <= |(status & mask);
      live   <= 1'b1;
    end
  end

  // R7: every event leaves its status bit set
  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ((status & $past(ev)) == $past(ev)));
  // R8: a write-1 without a concurrent event clears the bit
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ((status & $past(clr & ~ev)) == '0));
  // R9: interrupt follows masked status one cycle later
  a_r9_irq_reg: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (irq == |$past(status & mask)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned N_PINS = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_valid,
  input  logic                             reg_write,
  input  logic [gpio_port_pkg::ADDR_W-1:0] reg_addr,
  input  logic [N_PINS-1:0]                reg_wdata,
  output logic [N_PINS-1:0]                reg_rdata,
  input  logic [N_PINS-1:0]                pad_in,
  output logic [N_PINS-1:0]                pad_out,
  output logic [N_PINS-1:0]                pad_oe,
  output logic                             irq
);
  import gpio_port_pkg::*;

  localparam int unsigned HALF = N_PINS / 2;

  logic [N_PINS-1:0] out_q, dir_q, mask_q, any_q;
  logic [N_PINS-1:0] sns_lo_q, sns_hi_q;
  logic [N_PINS-1:0] pad_sync, ev, status, clr;
  logic [N_PINS-1:0] rd_mux;
  logic              wr_req, rd_req;

  assign wr_req = reg_valid && reg_write;
  assign rd_req = reg_valid && !reg_write;
  assign clr    = (wr_req && reg_addr == A_STATUS) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; dir_q <= '0; mask_q <= '0; any_q <= '0;
      sns_lo_q <= '0; sns_hi_q <= '0;
    end else if (wr_req) begin
      case (reg_addr)
        A_DATA:   out_q    <= reg_wdata;
        A_DIR:    dir_q    <= reg_wdata;
        A_MASK:   mask_q   <= reg_wdata;
        A_SNS_LO: sns_lo_q <= reg_wdata;
        A_SNS_HI: sns_hi_q <= reg_wdata;
        A_ANYEDG: any_q    <= reg_wdata;
        default:  ;
      endcase
    end
  end

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpio_detect #(.N(N_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur(pad_sync),
    .sense({sns_hi_q, sns_lo_q}), .any_edge(any_q), .ev(ev)
  );

  gpio_status #(.N(N_PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr), .mask(mask_q),
    .status(status), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      A_DATA:   rd_mux = (out_q & dir_q) | (pad_sync & ~dir_q);
      A_DIR:    rd_mux = dir_q;
      A_PAD:    rd_mux = pad_sync;
      A_MASK:   rd_mux = mask_q;
      A_STATUS: rd_mux = status;
      A_SNS_LO: rd_mux = sns_lo_q;
      A_SNS_HI: rd_mux = sns_hi_q;
      default:  rd_mux = any_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (rd_req) reg_rdata <= rd_mux;
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  initial begin
    a_r5_two_halves: assert (2 * HALF == N_PINS);
  end

  // R10: read data changes only after a read request
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_req) |-> $stable(reg_rdata));
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, pad_out, pad_oe;
  logic [31:0] pad_in = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {pin[4:0], code[1:0], any, first level, second level, expected status}
  localparam int NV = 11;
  localparam logic [10:0] VEC [NV] = '{
    {5'd3,  2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd3,  2'b00, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd7,  2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd7,  2'b01, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd16, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd16, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd31, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd31, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd20, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd20, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0},
    {5'd15, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin_cfg(input int pin, input logic [1:0] code, input logic any);
    logic [31:0] v;
    logic [2:0]  a;
    int sh;
    a  = (pin < 16) ? 3'd5 : 3'd6;
    sh = 2 * (pin % 16);
    rd(a, v);
    v = (v & ~(32'h3 << sh)) | (32'(code) << sh);
    wr(a, v);
    rd(3'd7, v);
    v[pin] = any;
    wr(3'd7, v);
  endtask

  initial begin : watchdog
    int n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] v;
    wait_cyc(3);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(3'd0, v); check("R1 data", v, 32'h0);
    rd(3'd1, v); check("R1 dir", v, 32'h0);
    rd(3'd3, v); check("R1 mask", v, 32'h0);
    rd(3'd5, v); check("R1 sense lo", v, 32'h0);
    rd(3'd6, v); check("R1 sense hi", v, 32'h0);
    rd(3'd7, v); check("R1 anyedge", v, 32'h0);

    // R7: level-low default sets status although masked
    wait_cyc(4);
    rd(3'd4, v); check("R7 masked level sets status", v, 32'hFFFF_FFFF);
    check("R7 irq stays low while masked", {31'h0, irq}, 32'h0);

    // Vector table: R5 codes, R6 any-edge override, R7/R8 status
    for (int i = 0; i < NV; i++) begin
      int pin;
      pin = int'(VEC[i][10:6]);
      set_pin_cfg(pin, VEC[i][5:4], VEC[i][3]);
      pad_in[pin] = VEC[i][2];
      wait_cyc(6);
      wr(3'd4, 32'h1 << pin);
      pad_in[pin] = VEC[i][1];
      wait_cyc(6);
      rd(3'd4, v);
      check($sformatf("R5/R6 vector %0d pin %0d", i, pin), {31'h0, v[pin]}, {31'h0, VEC[i][0]});
    end

    // R4: two-edge synchroniser, seen through the pad register
    pad_in = 32'h1234_5678;
    wait_cyc(4);
    rd(3'd2, v); check("R4 pad view", v, 32'h1234_5678);

    // R2 and R3: direction, output latch, data read merge
    wr(3'd0, 32'hA5A5_C3C3);
    wr(3'd1, 32'hFFFF_0000);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    check("R2 pad_out", pad_out, 32'hA5A5_C3C3);
    rd(3'd0, v); check("R3 data merge", v, 32'hA5A5_5678);
    rd(3'd2, v); check("R3 pad register ignores direction", v, 32'h1234_5678);
    wr(3'd2, 32'hDEAD_BEEF);
    rd(3'd2, v); check("R3 pad register ignores writes", v, 32'h1234_5678);

    // R10: write isolation
    wr(3'd3, 32'h0);
    rd(3'd1, v); check("R10 dir unchanged by mask write", v, 32'hFFFF_0000);
    rd(3'd0, v); check("R10 data unchanged by mask write", v, 32'hA5A5_5678);

    // R9: exact irq latency on pin 9 rising edge
    set_pin_cfg(9, 2'b10, 1'b0);
    pad_in[9] = 1'b0;
    wait_cyc(5);
    wr(3'd4, 32'h1 << 9);
    wr(3'd3, 32'h1 << 9);
    wait_cyc(2);
    check("R9 irq idle", {31'h0, irq}, 32'h0);
    pad_in[9] = 1'b1;
    wait_cyc(3);
    check("R9 irq low after three edges", {31'h0, irq}, 32'h0);
    wait_cyc(1);
    check("R9 irq high on fourth edge", {31'h0, irq}, 32'h1);

    // R8: writing zero or another bit does not clear
    wr(3'd4, 32'h0);
    wr(3'd4, 32'h1 << 16);
    rd(3'd4, v); check("R8 zero write keeps bit", {31'h0, v[9]}, 32'h1);
    check("R8 irq held", {31'h0, irq}, 32'h1);
    wr(3'd4, 32'h1 << 9);
    wait_cyc(2);
    rd(3'd4, v); check("R8 write-1 clears", {31'h0, v[9]}, 32'h0);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // R8: set wins over clear for a held level (pin 7 high-level, pad high)
    set_pin_cfg(7, 2'b01, 1'b0);
    pad_in[7] = 1'b1;
    wait_cyc(5);
    wr(3'd4, 32'h1 << 7);
    rd(3'd4, v); check("R8 level re-sets after clear", {31'h0, v[7]}, 32'h1);

    // R9: mask removal drops irq while status stays set
    wr(3'd3, 32'h1 << 7);
    wait_cyc(3);
    check("R9 irq from level pin", {31'h0, irq}, 32'h1);
    wr(3'd3, 32'h0);
    wait_cyc(2);
    check("R9 irq low when masked", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule